// File: doc/BRIEF.md
# Packed Signed Word Multiply-Add Unit

This unit is a 128-bit SIMD execution slice that splits each operand into eight signed 16-bit lanes. For every lane it multiplies the first two source words, adds the third source word, and keeps only the low 16 bits of the sum. Overflow wraps modulo 2^16. There is no saturation and no status output. All lanes work in parallel and do not affect one another.

The unit has two pipeline stages. The first stage multiplies. The second stage adds and truncates. A new operation can be issued on every clock, and its result appears two cycles later. When the accumulate input is raised with an operation, the unit ignores the third source bus and adds the most recent result instead. This lets a chain of back-to-back operations build a running sum in each lane.

Top module: `simd_madd16`

## Requirements
- R1: Lane i of every operand and of the result occupies bits [16i+15:16i], and lane i of the result depends only on lane i of the inputs.
- R2: Each lane multiplies the two source words as two's-complement signed values.
- R3: In normal mode each lane adds the sign-extended word of `in_c` from the same lane to the product.
- R4: Each lane's result is the low 16 bits of (a*b + addend). It wraps modulo 2^16 with no saturation, so for example 0x7FFF*0x7FFF + 0x7FFF gives 0x8000.
- R5: An overflow or carry in one lane never changes the result of any other lane.
- R6: `out_valid` is high exactly two clock cycles after `in_valid` was high. Operations issued on consecutive cycles produce results on consecutive cycles, in issue order.
- R7: When `in_acc` is 1 together with `in_valid`, the value on `in_c` is ignored. The most recent result is used as the addend instead.
- R8: Back-to-back accumulate operations each add to the sum produced by the operation issued one cycle earlier.
- R9: A synchronous active-high `rst` clears `out_valid`, the pipeline valid state and the result/accumulator register to zero. An accumulate operation issued right after reset therefore adds zero.
- R10: While `out_valid` is low, `out_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| in_acc | input | 1 | Use the last result as the addend instead of `in_c` |
| in_a | input | LANES*LANE_W | First multiplicand, packed lanes |
| in_b | input | LANES*LANE_W | Second multiplicand, packed lanes |
| in_c | input | LANES*LANE_W | Addend, packed lanes |
| out_valid | output | 1 | Result is valid this cycle |
| out_data | output | LANES*LANE_W | Packed 16-bit lane results (accumulator) |

## Verification
The bench builds the unit with its default LANES=8 and LANE_W=16, which is the full 128-bit shape. At this width the operands reach the real extremes -32768 and 32767, so the wrap of the full-scale product and of the add can both be hit in a single lane. Having eight lanes also makes it possible to put an overflowing lane directly next to a small one. The accumulate chain is run with a changing third-source bus, which shows that the bus is ignored and that the feedback is forwarded on consecutive cycles.

// File: rtl/simd_madd16.sv
module simd_madd16 #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_acc,
  input  logic [LANES*LANE_W-1:0]  in_a,
  input  logic [LANES*LANE_W-1:0]  in_b,
  input  logic [LANES*LANE_W-1:0]  in_c,
  output logic                     out_valid,
  output logic [LANES*LANE_W-1:0]  out_data
);
  localparam int VW = LANES * LANE_W;

  logic          s1_valid, s1_acc;
  logic [VW-1:0] prod_lo, s1_prod, s1_c, addend, sum, res_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LO = i * LANE_W;
    assign prod_lo[LO +: LANE_W] = in_a[LO +: LANE_W] * in_b[LO +: LANE_W];
    assign sum[LO +: LANE_W]     = s1_prod[LO +: LANE_W] + addend[LO +: LANE_W];
  end

  assign addend   = s1_acc ? res_q : s1_c;
  assign out_data = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_acc   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_acc   <= in_acc;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_prod <= prod_lo;
      s1_c    <= in_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) res_q <= sum;
    end
  end
endmodule

// File: rtl/simd_madd16_chk.sv
module simd_madd16_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_acc,
  input logic [LANES*LANE_W-1:0] in_a,
  input logic [LANES*LANE_W-1:0] in_b,
  input logic [LANES*LANE_W-1:0] in_c,
  input logic                    out_valid,
  input logic [LANES*LANE_W-1:0] out_data
);
  localparam int VW = LANES * LANE_W;

  function automatic logic [VW-1:0] ref_madd(input logic [VW-1:0] a, b, c);
    logic [VW-1:0] r;
    logic signed [2*LANE_W-1:0] p;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      p = $signed(a[i*LANE_W +: LANE_W]) * $signed(b[i*LANE_W +: LANE_W]);
      p = p + {{LANE_W{c[i*LANE_W+LANE_W-1]}}, c[i*LANE_W +: LANE_W]};
      r[i*LANE_W +: LANE_W] = p[LANE_W-1:0];
    end
    return r;
  endfunction

  logic [1:0] cyc;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    if (rst_q === 1'b1)
      AST_RESET: assert (!out_valid && out_data == '0); // R9
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1 && !out_valid) |-> $stable(out_data)); // R10

  AST_WRAP_SUM: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && out_valid && !$past(in_acc, 2)) |->
      (out_data == ref_madd($past(in_a, 2), $past(in_b, 2), $past(in_c, 2)))); // R4

  AST_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && out_valid && $past(in_acc, 2)) |->
      (out_data == ref_madd($past(in_a, 2), $past(in_b, 2), $past(out_data)))); // R8
endmodule

bind simd_madd16 simd_madd16_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
  .in_a(in_a), .in_b(in_b), .in_c(in_c),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_simd_madd16.sv
module test_simd_madd16;
  localparam int LN = 8;
  localparam int LW = 16;
  localparam int VW = LN * LW;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_acc = 1'b0;
  logic [VW-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;

  always #2 clk = ~clk;

  simd_madd16 i_simd_madd16 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0, bad = 0;
  logic [VW-1:0] mout = '0;
  logic [VW-1:0] qa[16], qb[16], qc[16];
  logic          qv[16], qacc[16];

  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, b, c);
    logic [VW-1:0] r;
    for (int i = 0; i < LN; i++) begin
      int x;
      x = int'($signed(a[i*LW +: LW])) * int'($signed(b[i*LW +: LW])) + int'($signed(c[i*LW +: LW]));
      r[i*LW +: LW] = x[LW-1:0];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input int k, input logic [VW-1:0] a, b, c, input logic v, acc);
    qa[k] = a; qb[k] = b; qc[k] = c; qv[k] = v; qacc[k] = acc;
  endtask

  task automatic run(input int n, input string req);
    for (int t = 0; t < n + 2; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        if (qv[t-2]) begin
          logic [VW-1:0] e;
          e = model(qa[t-2], qb[t-2], qacc[t-2] ? mout : qc[t-2]);
          chk(out_valid === 1'b1, "R6 valid", {{VW-1{1'b0}}, out_valid}, 1);
          chk(out_data === e, req, out_data, e);
          mout = e;
        end else begin
          chk(out_valid === 1'b0, "R6 idle", {{VW-1{1'b0}}, out_valid}, 0);
          chk(out_data === mout, "R10 hold", out_data, mout);
        end
      end
      if (t < n) begin
        in_valid = qv[t]; in_acc = qacc[t]; in_a = qa[t]; in_b = qb[t]; in_c = qc[t];
      end else begin
        in_valid = 1'b0; in_acc = 1'b0;
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9 valid", {{VW-1{1'b0}}, out_valid}, 0);
    chk(out_data === '0, "R9 data", out_data, '0);
    rst = 1'b0;
    mout = '0;
  endtask

  task automatic t_basic;
    logic [VW-1:0] a, b, c;
    for (int i = 0; i < LN; i++) begin
      a[i*LW +: LW] = LW'(i + 1);
      b[i*LW +: LW] = LW'(-(i + 2));
      c[i*LW +: LW] = LW'(100 * i);
    end
    put(0, a, b, c, 1'b1, 1'b0);
    run(1, "R2 R3 signed multiply-add");
    chk(out_data[15:0] === 16'hFFFE, "R1 lane0", out_data, 16'hFFFE);
    chk(out_data[127:112] === 16'h0274, "R1 lane7", out_data[127:112], 16'h0274);
  endtask

  task automatic t_wrap;
    logic [VW-1:0] a, b, c;
    a = '0; b = '0; c = '0;
    a[15:0] = 16'h7FFF; b[15:0] = 16'h7FFF; c[15:0] = 16'h7FFF;
    a[31:16] = 16'h8000; b[31:16] = 16'h8000; c[31:16] = 16'hFFFF;
    a[47:32] = 16'h8000; b[47:32] = 16'h0001; c[47:32] = 16'h8000;
    a[63:48] = 16'hFFFF; b[63:48] = 16'hFFFF; c[63:48] = 16'hFFFF;
    put(0, a, b, c, 1'b1, 1'b0);
    run(1, "R4 wrap");
    chk(out_data[15:0] === 16'h8000, "R4 max", out_data[15:0], 16'h8000);
    chk(out_data[31:16] === 16'hFFFF, "R4 min", out_data[31:16], 16'hFFFF);
    chk(out_data[47:32] === 16'h0000, "R4 neg wrap", out_data[47:32], 16'h0000);
    chk(out_data[63:48] === 16'h0000, "R2 minus one squared", out_data[63:48], 16'h0000);
  endtask

  task automatic t_isolate;
    logic [VW-1:0] a, b, c, solo;
    a = '0; b = '0; c = '0;
    a[63:48] = 16'd7; b[63:48] = 16'd9; c[63:48] = 16'd5;
    put(0, a, b, c, 1'b1, 1'b0);
    for (int i = 0; i < LN; i++)
      if (i != 3) begin
        a[i*LW +: LW] = 16'h7FFF; b[i*LW +: LW] = 16'h8001; c[i*LW +: LW] = 16'h8000;
      end
    put(1, a, b, c, 1'b1, 1'b0);
    run(1, "R5 solo");
    solo = out_data;
    run(2, "R5 noisy");
    chk(out_data[63:48] === solo[63:48], "R5 isolation", out_data[63:48], solo[63:48]);
    chk(out_data[63:48] === 16'd68, "R5 lane3", out_data[63:48], 16'd68);
  endtask

  task automatic t_stream;
    for (int k = 0; k < 6; k++)
      put(k, {8{16'(k * 311 + 17)}}, {8{16'(16'hF00D - k * 77)}}, {8{16'(k * 4099)}}, k != 3, 1'b0);
    run(6, "R6 stream");
  endtask

  task automatic t_accum;
    put(0, {8{16'd3}}, {8{16'd5}}, {8{16'd1}}, 1'b1, 1'b0);
    for (int k = 1; k < 5; k++)
      put(k, {8{16'(k * 1000)}}, {8{16'(k * 33)}}, {8{16'(16'h5555 + k)}}, 1'b1, 1'b1);
    run(5, "R7 R8 accumulate");
    chk(out_data[15:0] === 16'(16 + 33000 + 132000 + 297000 + 528000), "R8 chain",
        out_data[15:0], 16'(16 + 33000 + 132000 + 297000 + 528000));
  endtask

  task automatic t_reset_acc;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_data === '0, "R9 acc cleared", out_data, '0);
    rst = 1'b0; mout = '0;
    put(0, {8{16'd3}}, {8{16'd4}}, {8{16'h1234}}, 1'b1, 1'b1);
    run(1, "R9 acc after reset");
    chk(out_data === {8{16'd12}}, "R9 R7 zero addend", out_data, {8{16'd12}});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL R6 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_wrap;
    t_isolate;
    t_stream;
    t_accum;
    t_reset_acc;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule